// File: doc/BRIEF.md
# Flash Flag Status Register

This block holds the eight-bit flag byte that a flash memory's program/erase engine exposes to the host. It collects several inputs: the engine's busy level, suspend and resume commands that have been accepted, one-cycle error events, and a clear-flags command. From them it keeps a byte that can be read at any moment, including while a program or erase operation is running.

Error flags are sticky. Once an error event has been seen, its flag stays set until the clear-flags command runs. That command needs no write-enable and leaves the ready and suspend flags alone. A suspend flag rises as soon as its suspend command is accepted, even if the engine goes on to finish the operation. A resume command drops both suspend flags. Every flag changes one clock after the input that causes it. The byte is always presented on `flagByte`.

Top module: `flag_status_reg`

## Requirements
- R1: After reset, `flagByte` reads 8'h80: ready (bit 7) set and every other bit 0.
- R2: Bit 7 is the inverse of `ctrlBusy` as sampled at the previous rising clock edge, and it can be read while the engine is busy.
- R3: An `eraseErrEvt` pulse sets bit 5 at the next edge. Bit 5 then stays set, whatever the other inputs do, until a clear-flags command.
- R4: The other error events set their own bits at the next edge, and those bits are sticky in the same way: `programErrEvt` sets bit 4, `supplyErrEvt` sets bit 3 and `protectErrEvt` sets bit 1.
- R5: A `clearFlags` pulse clears bits 5, 4, 3 and 1 at the next edge. The block has no write-enable input, so the command needs none.
- R6: A `clearFlags` pulse leaves bits 7, 6 and 2 unchanged.
- R7: When an error event and `clearFlags` arrive in the same cycle, that event's bit reads 1 afterwards.
- R8: `eraseSuspendReq` sets bit 6 and `programSuspendReq` sets bit 2 at the next edge. This happens even while `ctrlBusy` is still high.
- R9: `resumeReq` clears bits 6 and 2 at the next edge. A suspend request that arrives in the same cycle as a resume wins for its own bit.
- R10: Bit 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlBusy | input | 1 | Program/erase engine busy level |
| eraseSuspendReq | input | 1 | Pulse: erase suspend command accepted |
| programSuspendReq | input | 1 | Pulse: program suspend command accepted |
| resumeReq | input | 1 | Pulse: resume command accepted |
| eraseErrEvt | input | 1 | Pulse: erase failure (covers subsector, sector or bulk erase) |
| programErrEvt | input | 1 | Pulse: program failure |
| supplyErrEvt | input | 1 | Pulse: supply-voltage fault |
| protectErrEvt | input | 1 | Pulse: operation attempted on a protected area |
| clearFlags | input | 1 | Pulse: clear the error flags |
| flagByte | output | 8 | Current flag byte |

## Verification
The error events are raised one at a time, with idle cycles after each, so that every sticky bit is seen on its own position and is seen to hold. The clear command is tried in three situations: on its own, while suspend flags are set and the engine is busy, and in the same cycle as an error event. This separates the bits it must clear from the bits it must keep, and shows which one wins a collision. Suspend requests are issued while the engine is busy to show that the flag does not wait for the pause. A suspend request issued together with a resume shows the priority between the two.

// File: rtl/flag_status_pkg.sv
package flag_status_pkg;
  localparam int FLAG_W = 8;
  // Bit positions are decoded by the host; they are fixed.
  localparam int READY_BIT     = 7;
  localparam int ERASE_SUS_BIT = 6;
  localparam int ERASE_ERR_BIT = 5;
  localparam int PROG_ERR_BIT  = 4;
  localparam int SUPPLY_ERR_BIT = 3;
  localparam int PROG_SUS_BIT  = 2;
  localparam int PROT_ERR_BIT  = 1;
  localparam int RSV_BIT       = 0;

  localparam logic [FLAG_W-1:0] ERR_MASK =
    (FLAG_W'(1) << ERASE_ERR_BIT) | (FLAG_W'(1) << PROG_ERR_BIT) |
    (FLAG_W'(1) << SUPPLY_ERR_BIT) | (FLAG_W'(1) << PROT_ERR_BIT);
  localparam logic [FLAG_W-1:0] SUS_MASK =
    (FLAG_W'(1) << ERASE_SUS_BIT) | (FLAG_W'(1) << PROG_SUS_BIT);

  typedef struct packed {
    logic [FLAG_W-1:0] setMask;
    logic [FLAG_W-1:0] clrMask;
    logic              readyNext;
  } fsr_strobe_t;
endpackage

// File: rtl/flag_status_ctrl.sv
module flag_status_ctrl
  import flag_status_pkg::*;
(
  input  logic        ctrlBusy,
  input  logic        eraseSuspendReq,
  input  logic        programSuspendReq,
  input  logic        resumeReq,
  input  logic        eraseErrEvt,
  input  logic        programErrEvt,
  input  logic        supplyErrEvt,
  input  logic        protectErrEvt,
  input  logic        clearFlags,
  output fsr_strobe_t strobe
);
  always_comb begin
    strobe = '0;
    strobe.setMask[ERASE_ERR_BIT]  = eraseErrEvt;
    strobe.setMask[PROG_ERR_BIT]   = programErrEvt;
    strobe.setMask[SUPPLY_ERR_BIT] = supplyErrEvt;
    strobe.setMask[PROT_ERR_BIT]   = protectErrEvt;
    strobe.setMask[ERASE_SUS_BIT]  = eraseSuspendReq;
    strobe.setMask[PROG_SUS_BIT]   = programSuspendReq;
    strobe.clrMask = (clearFlags ? ERR_MASK : '0) | (resumeReq ? SUS_MASK : '0);
    strobe.readyNext = ~ctrlBusy;
  end
endmodule

// File: rtl/flag_status_dp.sv
module flag_status_dp
  import flag_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  fsr_strobe_t       strobe,
  output logic [FLAG_W-1:0] flags
);
  for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
    if (b == READY_BIT) begin : g_ready
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) flags[b] <= 1'b1;
        else       flags[b] <= strobe.readyNext;
    end else if (b == RSV_BIT) begin : g_rsv
      assign flags[b] = 1'b0;
    end else begin : g_sticky
      // A set in the same cycle as a clear wins.
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) flags[b] <= 1'b0;
        else       flags[b] <= (flags[b] & ~strobe.clrMask[b]) | strobe.setMask[b];
    end
  end
endmodule

// File: rtl/flag_status_reg.sv
module flag_status_reg
  import flag_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlBusy,
  input  logic              eraseSuspendReq,
  input  logic              programSuspendReq,
  input  logic              resumeReq,
  input  logic              eraseErrEvt,
  input  logic              programErrEvt,
  input  logic              supplyErrEvt,
  input  logic              protectErrEvt,
  input  logic              clearFlags,
  output logic [FLAG_W-1:0] flagByte
);
  fsr_strobe_t strobe;

  flag_status_ctrl u_ctrl (
    .ctrlBusy(ctrlBusy), .eraseSuspendReq(eraseSuspendReq),
    .programSuspendReq(programSuspendReq), .resumeReq(resumeReq),
    .eraseErrEvt(eraseErrEvt), .programErrEvt(programErrEvt),
    .supplyErrEvt(supplyErrEvt), .protectErrEvt(protectErrEvt),
    .clearFlags(clearFlags), .strobe(strobe)
  );

  flag_status_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .flags(flagByte)
  );
endmodule

// File: rtl/flag_status_chk.sv
module flag_status_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ctrlBusy,
  input logic       eraseSuspendReq,
  input logic       programSuspendReq,
  input logic       resumeReq,
  input logic       eraseErrEvt,
  input logic       programErrEvt,
  input logic       supplyErrEvt,
  input logic       protectErrEvt,
  input logic       clearFlags,
  input logic [7:0] flagByte
);
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN) flagByte[0] == 1'b0); // R10
  AST_READY_INV: assert property (@(posedge clk) disable iff (!rstN) 1'b1 |=> flagByte[7] == !$past(ctrlBusy)); // R2
  AST_ERASE_STICKY: assert property (@(posedge clk) disable iff (!rstN) flagByte[5] && !clearFlags |=> flagByte[5]); // R3
  AST_ERASE_SET: assert property (@(posedge clk) disable iff (!rstN) eraseErrEvt |=> flagByte[5]); // R3
  AST_PROG_STICKY: assert property (@(posedge clk) disable iff (!rstN) flagByte[4] && !clearFlags |=> flagByte[4]); // R4
  AST_PROT_STICKY: assert property (@(posedge clk) disable iff (!rstN) flagByte[1] && !clearFlags |=> flagByte[1]); // R4
  AST_CLEAR_ERR: assert property (@(posedge clk) disable iff (!rstN)
    clearFlags && !eraseErrEvt && !programErrEvt && !supplyErrEvt && !protectErrEvt
    |=> (flagByte & 8'h3A) == 8'h00); // R5
  AST_CLEAR_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    clearFlags && !resumeReq && !eraseSuspendReq && !programSuspendReq
    |=> $stable(flagByte[6]) && $stable(flagByte[2])); // R6
  AST_CLEAR_LOSES: assert property (@(posedge clk) disable iff (!rstN) clearFlags && supplyErrEvt |=> flagByte[3]); // R7
  AST_SUSPEND_SET: assert property (@(posedge clk) disable iff (!rstN) eraseSuspendReq |=> flagByte[6]); // R8
  AST_RESUME_CLR: assert property (@(posedge clk) disable iff (!rstN)
    resumeReq && !eraseSuspendReq && !programSuspendReq |=> !flagByte[6] && !flagByte[2]); // R9
endmodule

bind flag_status_reg flag_status_chk u_chk (.*);

// File: tb/flag_status_reg_bench.sv
module flag_status_reg_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlBusy = 0, eraseSuspendReq = 0, programSuspendReq = 0, resumeReq = 0;
  logic eraseErrEvt = 0, programErrEvt = 0, supplyErrEvt = 0, protectErrEvt = 0, clearFlags = 0;
  logic [7:0] flagByte;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flag_status_reg u_flag_status_reg (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: flagByte=%h expected %h", req, act, exp);
    end
  endtask

  // Hold the current inputs over one rising edge, then drop the pulse inputs.
  task automatic tick();
    @(posedge clk); #2;
    eraseSuspendReq = 0; programSuspendReq = 0; resumeReq = 0;
    eraseErrEvt = 0; programErrEvt = 0; supplyErrEvt = 0; protectErrEvt = 0; clearFlags = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    check("R1 reset value", flagByte, 8'h80);
    check("R10 reserved bit", {7'b0, flagByte[0]}, 8'h00);
  endtask

  task automatic t_ready();
    ctrlBusy = 1; tick();
    check("R2 busy clears ready", flagByte, 8'h00);
  endtask

  task automatic t_errors();
    eraseErrEvt = 1; tick();
    check("R3 erase error set", flagByte, 8'h20);
    tick();
    check("R3 erase error sticky", flagByte, 8'h20);
    ctrlBusy = 0; tick();
    check("R2 ready back, R3 held", flagByte, 8'hA0);
    programErrEvt = 1; tick();
    check("R4 program error bit4", flagByte, 8'hB0);
    supplyErrEvt = 1; tick();
    check("R4 supply error bit3", flagByte, 8'hB8);
    protectErrEvt = 1; tick();
    check("R4 protection error bit1", flagByte, 8'hBA);
    tick(); tick();
    check("R4 errors sticky", flagByte, 8'hBA);
  endtask

  task automatic t_suspend();
    ctrlBusy = 1; eraseSuspendReq = 1; tick();
    check("R8 erase suspend while busy", flagByte, 8'h7A);
    programSuspendReq = 1; tick();
    check("R8 program suspend bit2", flagByte, 8'h7E);
  endtask

  task automatic t_clear();
    clearFlags = 1; tick();
    check("R5 R6 clear errors keep 7/6/2", flagByte, 8'h44);
    clearFlags = 1; programErrEvt = 1; tick();
    check("R7 event beats clear", flagByte, 8'h54);
  endtask

  task automatic t_resume();
    resumeReq = 1; tick();
    check("R9 resume clears suspends", flagByte, 8'h10);
    ctrlBusy = 0; eraseSuspendReq = 1; resumeReq = 1; tick();
    check("R9 suspend beats resume", flagByte, 8'hD0);
    resumeReq = 1; tick();
    check("R9 second resume", flagByte, 8'h90);
    clearFlags = 1; tick();
    check("R5 final clear", flagByte, 8'h80);
    check("R10 reserved bit end", {7'b0, flagByte[0]}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_ready();
    t_errors();
    t_suspend();
    t_clear();
    t_resume();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: expired=1 expected 0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule